// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Stage

This block is a small processor built around one 16-bit accumulator. It runs a program from an external synchronous word memory with 4096 locations. Each instruction goes through the same sequence. The processor fetches the word at the program counter into an instruction register and advances the program counter. It then executes the instruction. Last, it checks for an interrupt before the next fetch begins.

The instruction set has load, store and add, all with one direct address. It also has a halt and a return from interrupt. Any other opcode does nothing.

A single request line can divert the program. The request is taken only at an instruction boundary and only while the enable bit of the status word is set. When it is taken, the processor pushes the return address and the status word onto an internal control stack. It then clears the enable bit, pulses an acknowledge for one cycle and continues at a fixed handler address. The return opcode pops the stack, which restores both the return address and the enable bit.

Top module: `accum_core`

## Requirements
- R1: An instruction word holds the opcode in bits 15:12 and a direct word address in bits 11:0.
- R2: Opcode 0x1 copies the addressed word into the accumulator. Opcode 0x5 adds the addressed word to the accumulator, modulo 2^16. Opcode 0x2 writes the accumulator to the addressed word.
- R3: After reset, the first fetch is from address 0x300, and each fetch advances the program counter by one. Running 0x1940, 0x5941, 0x2941 leaves mem[0x941] equal to the old mem[0x940] plus the old mem[0x941].
- R4: A store raises the memory write strobe for exactly one cycle, with the address and data of that store.
- R5: Opcode 0xF halts the processor. After that, the halted output stays high, and there are no memory writes and no acknowledges.
- R6: Every opcode other than 0x1, 0x2, 0x5, 0xE and 0xF leaves the accumulator and memory unchanged. Opcode 0xE has no effect when the control stack is empty.
- R7: A request is taken only when the current instruction has finished and interrupts are enabled. Taking it pushes the return address and the enable bit, and moves the program counter to 0xF00. The acknowledge is high for one cycle, in the same cycle as the fetch from 0xF00.
- R8: Taking an interrupt clears the enable bit, so a request held high during the handler is not taken again before the return.
- R9: Opcode 0xE pops the enable bit and the return address, so execution continues at the instruction after the one that was interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| mem_addr | output | 12 | Word address presented to the memory |
| mem_we | output | 1 | Write strobe for the memory |
| mem_wdata | output | 16 | Data written on a store |
| mem_rdata | input | 16 | Read data; valid one cycle after its address |
| irq_req | input | 1 | Interrupt request level |
| irq_ack | output | 1 | One-cycle pulse when a request is taken |
| halted | output | 1 | High once a halt opcode has executed |

## Verification
Instructions that do not read memory take four cycles: fetch, latch, execute and check. Load and add take five, because of the extra memory read. A store's write strobe is due in the execute cycle, which is the third cycle of its instruction. The acknowledge is due one cycle after the check stage that takes the request, in the same cycle as the fetch from the handler address.

The bench does not count cycles. A driver computes the expected stores from the program and the memory image and queues them in order. A monitor samples the strobe and the acknowledge on the falling edge and compares each write with the head of the queue. Ordering and timing are therefore judged by the order of writes at the port and by the address present during the acknowledge.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam int unsigned OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OP_RTI   = 4'hE;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_LATCH = 3'd1,
    ST_EXEC  = 3'd2,
    ST_MEMRD = 3'd3,
    ST_CHECK = 3'd4,
    ST_HALT  = 3'd5
  } cpu_state_e;

endpackage

// File: rtl/accum_stack.sv
module accum_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] sp_q, sp_d;
  logic [PTR_W-1:0] top_ptr;
  logic             do_push, do_pop, sp_en;

  assign empty   = (sp_q == '0);
  assign full    = (sp_q == PTR_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign sp_en   = do_push || do_pop;
  assign top_ptr = sp_q - PTR_W'(1);
  assign dout    = slot_q[top_ptr[IDX_W-1:0]];

  always_comb begin
    sp_d = sp_q;
    if (do_push)     sp_d = sp_q + PTR_W'(1);
    else if (do_pop) sp_d = sp_q - PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[sp_q[IDX_W-1:0]] <= din;
  end
endmodule

// File: rtl/accum_intc.sv
module accum_intc (
  input  logic at_boundary,
  input  logic int_en,
  input  logic req,
  input  logic stack_full,
  output logic take
);
  assign take = at_boundary && int_en && req && !stack_full;
endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned STACK_DEPTH  = 8,
  parameter logic [11:0] RESET_PC     = 12'h300,
  parameter logic [11:0] HANDLER_ADDR = 12'hF00
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [11:0] mem_addr,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        irq_req,
  output logic        irq_ack,
  output logic        halted
);
  localparam int unsigned ADDR_W = DATA_W - OPC_W;
  localparam int unsigned FRAME_W = ADDR_W + 1;

  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  cpu_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q, acc_q, acc_d;
  logic              ie_q, ie_d, ack_q, take;
  logic              pc_en, ir_en, acc_en, ie_en;
  logic              stk_push, stk_pop, stk_empty, stk_full;
  logic [FRAME_W-1:0] stk_top;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] operand;

  assign opcode  = ir_q[DATA_W-1:ADDR_W];
  assign operand = ir_q[ADDR_W-1:0];

  accum_intc u_intc (
    .at_boundary (state_q == ST_CHECK),
    .int_en      (ie_q),
    .req         (irq_req),
    .stack_full  (stk_full),
    .take        (take)
  );

  accum_stack #(.DEPTH(STACK_DEPTH), .W(FRAME_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_core_n),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   ({ie_q, pc_q}),
    .dout  (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    acc_d    = acc_q;
    ie_d     = ie_q;
    pc_en    = 1'b0;
    ir_en    = 1'b0;
    acc_en   = 1'b0;
    ie_en    = 1'b0;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    unique case (state_q)
      ST_FETCH: state_d = ST_LATCH;
      ST_LATCH: begin
        ir_en   = 1'b1;
        pc_en   = 1'b1;
        pc_d    = pc_q + ADDR_W'(1);
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_CHECK;
        if (opcode == OP_LOAD || opcode == OP_ADD) begin
          state_d = ST_MEMRD;
        end else if (opcode == OP_HALT) begin
          state_d = ST_HALT;
        end else if (opcode == OP_RTI && !stk_empty) begin
          stk_pop = 1'b1;
          pc_en   = 1'b1;
          ie_en   = 1'b1;
          pc_d    = stk_top[ADDR_W-1:0];
          ie_d    = stk_top[ADDR_W];
        end
      end
      ST_MEMRD: begin
        acc_en  = 1'b1;
        acc_d   = (opcode == OP_LOAD) ? mem_rdata : acc_q + mem_rdata;
        state_d = ST_CHECK;
      end
      ST_CHECK: begin
        state_d = ST_FETCH;
        if (take) begin
          stk_push = 1'b1;
          pc_en    = 1'b1;
          ie_en    = 1'b1;
          pc_d     = HANDLER_ADDR;
          ie_d     = 1'b0;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      acc_q   <= '0;
      ie_q    <= 1'b1;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= take;
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= mem_rdata;
      if (acc_en) acc_q <= acc_d;
      if (ie_en)  ie_q  <= ie_d;
    end
  end

  assign mem_addr  = (state_q == ST_EXEC || state_q == ST_MEMRD) ? operand : pc_q;
  assign mem_we    = (state_q == ST_EXEC) && (opcode == OP_STORE);
  assign mem_wdata = acc_q;
  assign irq_ack   = ack_q;
  assign halted    = (state_q == ST_HALT);
endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk #(
  parameter logic [11:0] HANDLER = 12'hF00
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] mem_addr,
  input logic        mem_we,
  input logic        irq_req,
  input logic        irq_ack,
  input logic        halted
);
  // R7: the acknowledge lasts one cycle
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R7: the acknowledge coincides with the fetch from the handler address
  assert_ack_handler_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> mem_addr == HANDLER);

  // R7: an acknowledge follows a request seen in the cycle before
  assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ack) |-> $past(irq_req));

  // R4: the write strobe lasts one cycle
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5: halt is sticky and quiet
  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !irq_ack));
endmodule

bind accum_core accum_core_chk #(.HANDLER(HANDLER_ADDR)) u_chk (.*);

// File: tb/sim_accum_core.sv
module sim_accum_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        irq_req;
  logic        irq_ack;
  logic        halted;

  int checks = 0;
  int errors = 0;
  int ack_count = 0;
  int cycles = 0;
  logic ack_addr_ok;
  logic drop_on_a11;

  typedef struct packed { logic [11:0] addr; logic [15:0] data; } wr_t;
  wr_t exp_q [$];

  logic [15:0] mem [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_req(irq_req),
    .irq_ack(irq_ack), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: scoreboard of writes and acknowledges
  always @(negedge clk) begin
    cycles++;
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.addr && mem_wdata == e.data, "R2/R4 store",
              {4'h0, mem_addr, mem_wdata}, {4'h0, e.addr, e.data});
      end
      if (drop_on_a11 && mem_addr == 12'hA11) irq_req = 1'b0;
    end
    if (rst_n && irq_ack) begin
      ack_count++;
      if (mem_addr != 12'hF00) ack_addr_ok = 1'b0;
    end
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  task automatic start(input string name);
    rst_n = 1'b0;
    irq_req = 1'b0;
    drop_on_a11 = 1'b0;
    ack_count = 0;
    ack_addr_ok = 1'b1;
    exp_q.delete();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    @(negedge clk);
    $display("-- %s", name);
  endtask

  task automatic release_and_run(input int limit);
    int n;
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    check(halted, "R5 halted reached", {31'd0, halted}, 32'd1);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected stores seen", exp_q.size(), 0);
  endtask

  task automatic expect_wr(input logic [11:0] a, input logic [15:0] d);
    exp_q.push_back('{addr: a, data: d});
  endtask

  initial begin
    rst_n = 1'b0;
    irq_req = 1'b0;
    drop_on_a11 = 1'b0;
    ack_addr_ok = 1'b1;
    repeat (3) @(negedge clk);

    // reset state, R3 start address
    check(!halted, "R5 reset halted", {31'd0, halted}, 0);
    check(!mem_we, "R4 reset write strobe", {31'd0, mem_we}, 0);
    check(!irq_ack, "R7 reset ack", {31'd0, irq_ack}, 0);
    check(mem_addr == 12'h300, "R3 reset fetch address", mem_addr, 32'h300);

    // R1 R2 R3: the add-and-store sequence
    start("sum program");
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941; mem[12'h303] = 16'hF000;
    mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
    expect_wr(12'h941, 16'h0005);
    release_and_run(200);
    check(mem[12'h941] == 16'h0005, "R3 sum in memory", mem[12'h941], 5);

    // R5: a halted processor ignores requests
    irq_req = 1'b1;
    repeat (20) @(negedge clk);
    check(ack_count == 0, "R5 no ack after halt", ack_count, 0);
    check(halted, "R5 halt sticky", {31'd0, halted}, 1);
    irq_req = 1'b0;

    // R2: add wraps modulo 2^16
    start("add wrap");
    mem[12'h300] = 16'h1950; mem[12'h301] = 16'h5951;
    mem[12'h302] = 16'h2952; mem[12'h303] = 16'hF000;
    mem[12'h950] = 16'hFFFF; mem[12'h951] = 16'h0002;
    expect_wr(12'h952, 16'h0001);
    release_and_run(200);

    // R6: unused opcodes and a return with an empty stack do nothing
    start("no-op opcodes");
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h3941;
    mem[12'h302] = 16'h0000; mem[12'h303] = 16'hE000;
    mem[12'h304] = 16'h7123; mem[12'h305] = 16'h2942;
    mem[12'h306] = 16'hF000;
    mem[12'h940] = 16'hBEEF; mem[12'h941] = 16'h1111;
    expect_wr(12'h942, 16'hBEEF);
    release_and_run(300);
    check(mem[12'h941] == 16'h1111, "R6 memory untouched", mem[12'h941], 32'h1111);
    check(ack_count == 0, "R6 no ack without request", ack_count, 0);

    // R7 R8 R9: interrupt taken after the first instruction
    start("interrupt");
    mem[12'h300] = 16'h1A00; mem[12'h301] = 16'h2A01;
    mem[12'h302] = 16'h1A02; mem[12'h303] = 16'h2A03;
    mem[12'h304] = 16'hF000;
    mem[12'hF00] = 16'h2A20; mem[12'hF01] = 16'h1A10;
    mem[12'hF02] = 16'h2A11; mem[12'hF03] = 16'h1A20;
    mem[12'hF04] = 16'hE000;
    mem[12'hA00] = 16'h1234; mem[12'hA02] = 16'h0042; mem[12'hA10] = 16'h7777;
    expect_wr(12'hA20, 16'h1234);
    expect_wr(12'hA11, 16'h7777);
    expect_wr(12'hA01, 16'h1234);
    expect_wr(12'hA03, 16'h0042);
    irq_req = 1'b1;
    drop_on_a11 = 1'b1;
    release_and_run(400);
    check(ack_count == 1, "R8 single ack while request held in handler", ack_count, 1);
    check(ack_addr_ok, "R7 ack with fetch from 0xF00", {31'd0, ack_addr_ok}, 1);
    check(mem[12'hA03] == 16'h0042, "R9 resumed after return", mem[12'hA03], 32'h42);

    finish_run();
  end
endmodule